// File: doc/BRIEF.md
# Coalescing Interrupt Controller with Watermark Qualification

This block gathers interrupt causes for a network device and drives one level-sensitive interrupt line toward a processor. The datapath raises causes through a set vector. Software reads the cause register to clear it, writes ones to clear chosen causes, rewrites the enable mask and toggles a global enable. A post can wait a programmable number of cycles so that bursts of packet events share one interrupt. A small group of urgent causes always posts at once.

Posts that wait are coalesced. A post that is already waiting is moved only when a new request would fire sooner. A request that would fire later leaves the waiting post unchanged. The receive-high and transmit-low watermark causes are treated separately. Each can raise the line only after an arming event: the receive side being drained, or the transmit side being filled. Every post attempt uses up both arming flags.

Cause bits: 0 soft, 1 rx-packet, 2 rx-high, 3 rx-drained, 4 rx-dma, 5 tx-packet, 6 tx-low, 7 tx-filled, 8 tx-dma. Bits 9 to 15 are reserved. The urgent group is bits 0, 3 and 7, which is mask 0x0089.

Top module: `irqc_top`

## Requirements
- R1: After reset the cause register reads 0, the mask reads 0x0047 (soft, rx-packet, rx-high, tx-low), the global enable is off, and irq and rsv_err are 0.
- R2: Bits of src_set in bits 0..8 are ORed into the cause register at the clock edge and stay set until cleared.
- R3: A clock edge with st_rd high clears every cause bit. Bits set by src_set in the same cycle are kept.
- R4: A write with st_we clears only the cause bits written as one. Bits written as zero are unchanged, and writing one to a clear bit does nothing.
- R5: A post whose qualified set includes a bit of the urgent group, or that occurs with a delay of 0, raises irq at the same edge. Any other post with delay D raises irq D edges after the edge that took the request.
- R6: A new delayed post replaces a waiting one only if its deadline is strictly earlier. Otherwise the waiting post keeps its deadline.
- R7: Cause bit 2 (rx-high) takes part in a post only if the receive side was drained (rx_drained) since the last post attempt. Any nonzero src_set counts as a post attempt and uses up that arming.
- R8: Cause bit 6 (tx-low) is qualified the same way by tx_filled.
- R9: When the cause register AND the mask becomes zero, irq falls at that edge and any waiting post is cancelled.
- R10: A mask write that changes the mask raises irq at once if the cause register AND the new mask is nonzero. Otherwise it lowers irq.
- R11: While the global enable is off, irq stays 0 and nothing is scheduled. Turning the enable on with the cause register AND the mask nonzero raises irq at once.
- R12: Reserved bits 9..15 never enter the cause register or the mask. Any attempt to set them through src_set, or to clear them through st_we, pulses rsv_err high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 16 | Cause set pulses from the datapath |
| rx_drained | input | 1 | Receive buffer emptied; arms rx-high |
| tx_filled | input | 1 | Transmit buffer filled; arms tx-low |
| en_we | input | 1 | Global enable write strobe |
| en_wdata | input | 1 | Global enable value |
| dly_we | input | 1 | Delay register write strobe |
| dly_wdata | input | DLY_W | Post delay in cycles |
| st_rd | input | 1 | Cause register read strobe (clears it) |
| st_we | input | 1 | Cause register write-one-to-clear strobe |
| st_wdata | input | 16 | Bits to clear |
| msk_we | input | 1 | Mask write strobe |
| msk_wdata | input | 16 | New mask |
| st_rdata | output | 16 | Cause register value |
| msk_rdata | output | 16 | Mask value |
| irq | output | 1 | Level interrupt line |
| rsv_err | output | 1 | Reserved-bit access pulse |

## Verification
Directed sequences cover several cases. A lone packet cause with a long delay shows the count. An urgent soft cause separates immediate from delayed posting. Two posts in opposite deadline orders show whether the earlier deadline wins. Watermark causes are sent with and without prior arming, and after an unrelated post has used up the arming. Mask and enable changes over pending causes show the immediate post and the clear. A long seeded random run mixes all strobes and small delays against a deadline model that tracks absolute cycle numbers rather than a down-counter. That run exposes mistakes in replacement order, in arming consumption, and in clear-versus-set precedence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_W      = 16;
  localparam int B_SOFT     = 0;
  localparam int B_RX_PKT   = 1;
  localparam int B_RX_HIGH  = 2;
  localparam int B_RX_DRAIN = 3;
  localparam int B_RX_DMA   = 4;
  localparam int B_TX_PKT   = 5;
  localparam int B_TX_LOW   = 6;
  localparam int B_TX_FILL  = 7;
  localparam int B_TX_DMA   = 8;
  localparam int N_USED     = 9;

  typedef logic [SRC_W-1:0] src_t;

  localparam src_t USED_BITS    = src_t'((1 << N_USED) - 1);
  localparam src_t RESET_MASK   = src_t'((1 << B_SOFT) | (1 << B_RX_PKT) |
                                         (1 << B_RX_HIGH) | (1 << B_TX_LOW));
  localparam src_t NODELAY_BITS = src_t'((1 << B_SOFT) | (1 << B_RX_DRAIN) |
                                         (1 << B_TX_FILL));

  // Cause register update: clears act on the old value, sets always survive.
  function automatic src_t f_next_status(input src_t cur, input src_t set,
                                         input logic rd, input logic we,
                                         input src_t wd);
    src_t clr;
    clr = rd ? '1 : (we ? wd : '0);
    return (cur & ~clr) | (set & USED_BITS);
  endfunction

  // Remove watermark causes whose arming event has not happened.
  function automatic src_t f_qualify(input src_t masked, input logic rx_ok,
                                     input logic tx_ok);
    src_t q;
    q = masked;
    if (!rx_ok) q[B_RX_HIGH] = 1'b0;
    if (!tx_ok) q[B_TX_LOW]  = 1'b0;
    return q;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  src_t src_set,
  input  logic st_rd,
  input  logic st_we,
  input  src_t st_wdata,
  input  logic msk_we,
  input  src_t msk_wdata,
  input  logic en_we,
  input  logic en_wdata,
  output src_t status_q,
  output src_t status_d,
  output src_t mask_q,
  output src_t mask_d,
  output logic en_q,
  output logic en_d,
  output logic post_evt,
  output logic reopen,
  output logic rsv_err
);
  logic rsv_hit;

  assign status_d = f_next_status(status_q, src_set, st_rd, st_we, st_wdata);
  assign mask_d   = msk_we ? (msk_wdata & USED_BITS) : mask_q;
  assign en_d     = en_we ? en_wdata : en_q;
  assign post_evt = |(src_set & USED_BITS);
  assign reopen   = (msk_we && (mask_d != mask_q)) || (en_d && !en_q);
  assign rsv_hit  = (|(src_set & ~USED_BITS)) || (st_we && |(st_wdata & ~USED_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= RESET_MASK;
      en_q     <= 1'b0;
      rsv_err  <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      en_q     <= en_d;
      rsv_err  <= rsv_hit;
    end
  end

  a_r12_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | mask_q) & ~USED_BITS) == '0);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && src_set == '0) |=> status_q == '0);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_rd && src_set == '0) |=> (status_q & $past(st_wdata)) == '0);
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rd && !st_we) |=> (status_q & $past(src_set & USED_BITS)) == $past(src_set & USED_BITS));
endmodule

// File: rtl/irqc_qual.sv
module irqc_qual import irqc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic post_evt,
  input  logic rx_arm,
  input  logic tx_arm,
  input  src_t masked,
  output src_t qualified,
  output logic rx_armed,
  output logic tx_armed
);
  assign qualified = post_evt ? f_qualify(masked, rx_armed, tx_armed) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_armed <= 1'b0;
      tx_armed <= 1'b0;
    end else begin
      if (rx_arm)        rx_armed <= 1'b1;
      else if (post_evt) rx_armed <= 1'b0;
      if (tx_arm)        tx_armed <= 1'b1;
      else if (post_evt) tx_armed <= 1'b0;
    end
  end

  a_r7_rx_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && !rx_arm) |=> !rx_armed);
  a_r8_tx_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && !tx_arm) |=> !tx_armed);
endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             now,
  input  logic             sched,
  input  logic [DLY_W-1:0] dly,
  output logic             irq,
  output logic             pending
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             irq_d, pend_d, fire;

  // A new deadline wins only when strictly earlier than the remaining time.
  function automatic logic f_earlier(input logic pend, input logic [DLY_W-1:0] remain,
                                     input logic [DLY_W-1:0] d);
    return !pend || (d < remain);
  endfunction

  assign fire = pending && (cnt_q == DLY_W'(1));

  always_comb begin
    irq_d  = irq;
    pend_d = pending;
    cnt_d  = pending ? (cnt_q - DLY_W'(1)) : cnt_q;
    if (kill) begin
      irq_d  = 1'b0;
      pend_d = 1'b0;
    end else if (now || irq || fire) begin
      irq_d  = 1'b1;
      pend_d = 1'b0;
    end else if (sched && f_earlier(pending, cnt_d, dly)) begin
      pend_d = 1'b1;
      cnt_d  = dly;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      pending <= 1'b0;
      cnt_q   <= '0;
    end else begin
      irq     <= irq_d;
      pending <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r6_pending_count: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (cnt_q != '0));
  a_r6_line_or_wait: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !pending);
  a_r9_kill_drops: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!irq && !pending));
endmodule

// File: rtl/irqc_top.sv
module irqc_top import irqc_pkg::*; #(
  parameter int   DLY_W     = 16,
  parameter int   DEF_DELAY = 8,
  parameter src_t NODELAY   = NODELAY_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_set,
  input  logic             rx_drained,
  input  logic             tx_filled,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  input  logic             st_rd,
  input  logic             st_we,
  input  logic [SRC_W-1:0] st_wdata,
  input  logic             msk_we,
  input  logic [SRC_W-1:0] msk_wdata,
  output logic [SRC_W-1:0] st_rdata,
  output logic [SRC_W-1:0] msk_rdata,
  output logic             irq,
  output logic             rsv_err
);
  src_t status_q, status_d, mask_q, mask_d, masked_d, qualified;
  logic en_q, en_d, post_evt, reopen, rx_armed, tx_armed;
  logic hit, urgent, now, kill, pending;
  logic [DLY_W-1:0] dly_q;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .st_rd(st_rd), .st_we(st_we),
    .st_wdata(st_wdata), .msk_we(msk_we), .msk_wdata(msk_wdata), .en_we(en_we),
    .en_wdata(en_wdata), .status_q(status_q), .status_d(status_d), .mask_q(mask_q),
    .mask_d(mask_d), .en_q(en_q), .en_d(en_d), .post_evt(post_evt), .reopen(reopen),
    .rsv_err(rsv_err)
  );

  assign masked_d = status_d & mask_d;

  irqc_qual u_qual (
    .clk(clk), .rst_n(rst_n), .post_evt(post_evt), .rx_arm(rx_drained),
    .tx_arm(tx_filled), .masked(masked_d), .qualified(qualified),
    .rx_armed(rx_armed), .tx_armed(tx_armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dly_q <= DLY_W'(DEF_DELAY);
    else if (dly_we) dly_q <= dly_wdata;
  end

  assign hit    = |qualified;
  assign urgent = |(qualified & NODELAY);
  assign now    = (reopen && |masked_d) || (hit && (urgent || dly_q == '0));
  assign kill   = !en_d || (masked_d == '0);

  irqc_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kill(kill), .now(now), .sched(hit),
    .dly(dly_q), .irq(irq), .pending(pending)
  );

  assign st_rdata  = status_q;
  assign msk_rdata = mask_q;

  a_r9_line_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q && (status_q & mask_q) != '0));
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!irq && !pending));
  a_r5_urgent_now: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !kill) |=> irq);
  a_r10_reopen_now: assert property (@(posedge clk) disable iff (!rst_n)
    (reopen && !kill) |=> irq);
  a_r7_armed_known: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && !rx_armed) |-> !qualified[B_RX_HIGH]);
  a_r8_armed_known: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && !tx_armed) |-> !qualified[B_TX_LOW]);
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam logic [15:0] RSV = 16'hFE00;
  localparam logic [15:0] ND  = 16'h0089;
  localparam logic [15:0] RXH = 16'h0004;
  localparam logic [15:0] TXL = 16'h0040;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, rx_drained, tx_filled, en_we, en_wdata, dly_we, st_rd, st_we, msk_we;
  logic [15:0] src_set, st_wdata, msk_wdata, dly_wdata;
  wire  [15:0] st_rdata, msk_rdata;
  wire         irq, rsv_err;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .rx_drained(rx_drained),
    .tx_filled(tx_filled), .en_we(en_we), .en_wdata(en_wdata), .dly_we(dly_we),
    .dly_wdata(dly_wdata), .st_rd(st_rd), .st_we(st_we), .st_wdata(st_wdata),
    .msk_we(msk_we), .msk_wdata(msk_wdata), .st_rdata(st_rdata),
    .msk_rdata(msk_rdata), .irq(irq), .rsv_err(rsv_err)
  );

  int checks = 0, errors = 0, wd = 0;
  bit done = 0;

  // Reference model: deadlines kept as absolute edge numbers.
  logic [15:0] m_st, m_mk;
  logic m_en, m_rxa, m_txa, m_irq, m_pend, m_err;
  int m_dly, m_dl, ecount;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_st = 0; m_mk = 16'h0047; m_en = 0; m_rxa = 0; m_txa = 0;
    m_irq = 0; m_pend = 0; m_err = 0; m_dly = 8; m_dl = 0; ecount = 0;
  endtask

  task automatic m_step();
    logic [15:0] clr, setv, nst, nmk, q;
    logic nen, chg, rise, fire;
    setv = src_set & ~RSV;
    clr  = st_rd ? 16'hFFFF : (st_we ? st_wdata : 16'h0);
    nst  = (m_st & ~clr) | setv;
    nmk  = msk_we ? (msk_wdata & ~RSV) : m_mk;
    chg  = msk_we && (nmk != m_mk);
    nen  = en_we ? en_wdata : m_en;
    rise = nen && !m_en;
    q    = 16'h0;
    if (setv != 0) begin
      q = nst & nmk;
      if (!m_rxa) q = q & ~RXH;
      if (!m_txa) q = q & ~TXL;
      m_rxa = 0; m_txa = 0;
    end
    if (rx_drained) m_rxa = 1;
    if (tx_filled)  m_txa = 1;
    m_err = ((src_set & RSV) != 0) || (st_we && (st_wdata & RSV) != 0);
    fire = m_pend && (m_dl == ecount);
    if (!nen || (nst & nmk) == 0) begin
      m_irq = 0; m_pend = 0;
    end else if (((chg || rise)) || (q != 0 && ((q & ND) != 0 || m_dly == 0))) begin
      m_irq = 1; m_pend = 0;
    end else if (m_irq || fire) begin
      m_irq = 1; m_pend = 0;
    end else if (q != 0 && (!m_pend || ecount + m_dly < m_dl)) begin
      m_pend = 1; m_dl = ecount + m_dly;
    end
    if (dly_we) m_dly = int'(dly_wdata);
    m_st = nst; m_mk = nmk; m_en = nen;
    ecount++;
  endtask

  task automatic idle_in();
    src_set = 0; rx_drained = 0; tx_filled = 0; en_we = 0; en_wdata = 0;
    dly_we = 0; dly_wdata = 0; st_rd = 0; st_we = 0; st_wdata = 0;
    msk_we = 0; msk_wdata = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    idle_in();
  endtask

  task automatic do_set(input logic [15:0] v);  src_set = v; tick(); endtask
  task automatic do_dly(input int d);   dly_we = 1; dly_wdata = 16'(d); tick(); endtask
  task automatic do_rd();               st_rd = 1; tick(); endtask
  task automatic do_w1c(input logic [15:0] v);  st_we = 1; st_wdata = v; tick(); endtask
  task automatic do_msk(input logic [15:0] v);  msk_we = 1; msk_wdata = v; tick(); endtask
  task automatic do_en(input logic v);  en_we = 1; en_wdata = v; tick(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle_in();
    rst_n = 0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 status", st_rdata, 16'h0);
    chk("R1 mask", msk_rdata, 16'h0047);
    chk("R1 irq", irq, 0);
    chk("R1 rsv_err", rsv_err, 0);

    do_en(1);
    chk("R11 enable with nothing masked", irq, 0);

    // R5 delayed post, R2 set
    do_dly(4);
    do_set(16'h0002);
    chk("R2 status set", st_rdata, 16'h0002);
    chk("R5 not yet", irq, 0);
    repeat (3) tick();
    chk("R5 before deadline", irq, 0);
    tick();
    chk("R5 at deadline", irq, 1);

    // R3 read clears, R9 line drops
    do_rd();
    chk("R3 read clears", st_rdata, 16'h0);
    chk("R9 line drops", irq, 0);
    st_rd = 1; src_set = 16'h0020; tick();
    chk("R3 same-cycle set kept", st_rdata, 16'h0020);
    do_rd();

    // R5 urgent, R4 write-one-to-clear
    do_set(16'h0001);
    chk("R5 urgent immediate", irq, 1);
    do_set(16'h0002);
    do_w1c(16'h0001);
    chk("R4 clears one bit", st_rdata, 16'h0002);
    chk("R4 line held", irq, 1);
    do_w1c(16'h0010);
    chk("R4 clear of unset bit", st_rdata, 16'h0002);
    do_w1c(16'h0002);
    chk("R9 cleared to zero", irq, 0);

    // R6 earlier deadline replaces
    do_dly(10);
    do_set(16'h0002);
    do_dly(2);
    tick();
    do_set(16'h0002);
    chk("R6 early pending", irq, 0);
    tick();
    chk("R6 early pending 2", irq, 0);
    tick();
    chk("R6 earlier deadline wins", irq, 1);
    do_rd();

    // R6 later deadline ignored
    do_dly(3);
    do_set(16'h0002);
    do_dly(20);
    do_set(16'h0002);
    chk("R6 later not yet", irq, 0);
    tick();
    chk("R6 later deadline ignored", irq, 1);
    do_rd();

    // R7 rx-high qualification
    do_dly(1);
    do_set(16'h0004);
    tick(); tick();
    chk("R7 unarmed no post", irq, 0);
    chk("R7 status still recorded", st_rdata, 16'h0004);
    do_rd();
    rx_drained = 1; tick();
    do_set(16'h0004);
    tick();
    chk("R7 armed posts", irq, 1);
    do_rd();
    do_set(16'h0004);
    tick();
    chk("R7 arming consumed", irq, 0);
    do_rd();
    rx_drained = 1; tick();
    do_set(16'h0002);
    tick();
    do_rd();
    do_set(16'h0004);
    tick();
    chk("R7 consumed by other post", irq, 0);
    do_rd();

    // R8 tx-low qualification
    do_set(16'h0040);
    tick();
    chk("R8 unarmed no post", irq, 0);
    do_rd();
    tx_filled = 1; tick();
    do_set(16'h0040);
    tick();
    chk("R8 armed posts", irq, 1);
    do_rd();
    do_set(16'h0040);
    tick();
    chk("R8 arming consumed", irq, 0);
    do_rd();

    // R10 mask change
    do_dly(30);
    do_set(16'h0010);
    chk("R10 masked-out cause", irq, 0);
    do_msk(16'h0057);
    chk("R10 mask reads back", msk_rdata, 16'h0057);
    chk("R10 reopen posts now", irq, 1);
    do_msk(16'h0047);
    chk("R10 mask removes cause", irq, 0);
    do_rd();

    // R11 global enable
    do_en(0);
    do_set(16'h0001);
    chk("R11 disabled quiet", irq, 0);
    chk("R11 status while disabled", st_rdata, 16'h0001);
    do_en(1);
    chk("R11 enable posts", irq, 1);
    do_en(0);
    chk("R11 disable drops", irq, 0);
    do_en(1);
    do_rd();

    // R12 reserved bits
    do_set(16'h1000);
    chk("R12 reserved not stored", st_rdata, 16'h0);
    chk("R12 error pulse", rsv_err, 1);
    tick();
    chk("R12 error one cycle", rsv_err, 0);
    do_w1c(16'h8000);
    chk("R12 reserved clear error", rsv_err, 1);
    do_msk(16'hFFFF);
    chk("R12 mask reserved dropped", msk_rdata, 16'h01FF);
    do_msk(16'h0047);
    do_rd();

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 35) begin
        src_set = 16'(1) << ($urandom % 16);
        if ($urandom % 4 == 0) src_set = src_set | (16'(1) << ($urandom % 9));
      end
      rx_drained = ($urandom % 10 == 0);
      tx_filled  = ($urandom % 10 == 0);
      st_rd      = ($urandom % 20 == 0);
      if ($urandom % 10 == 0) begin st_we = 1; st_wdata = 16'($urandom); end
      if ($urandom % 20 == 0) begin msk_we = 1; msk_wdata = 16'($urandom) & 16'h01FF; end
      if ($urandom % 30 == 0) begin en_we = 1; en_wdata = ($urandom % 10 != 0); end
      if ($urandom % 20 == 0) begin dly_we = 1; dly_wdata = 16'($urandom % 13); end
      tick();
      chk("R6 irq vs model", irq, m_irq);
      chk("R2 status vs model", st_rdata, m_st);
      chk("R10 mask vs model", msk_rdata, m_mk);
      chk("R12 rsv_err vs model", rsv_err, m_err);
    end

    finish_run();
  end
endmodule